// File: doc/BRIEF.md
# Recall Line-Break Controller

This block turns a recall key code into a timed break on the subscriber line. A code strobe carries a 5-bit key code. When the recall code arrives and no earlier flash is still in its spacing window, the block pulls the active-low line output low for a short or a long interval. The interval is chosen by a duration-select input, which is sampled once when the break starts. While the line is broken, both mute outputs are high and a keyboard-inhibit flag is raised. On the first break cycle the block sends a one-cycle clear to the read pointer of the redial store. The stored digits themselves are not touched, so a later redial still works.

Every other code goes on to the redial store through a forwarding port, one cycle later. Recall codes are never forwarded. Nothing at all is forwarded while a break runs. All durations are counted in pulses of a millisecond tick input. By default a short break lasts 100 ticks and a long break 600 ticks. A spacing timer starts together with the break and runs for 810 ticks (short) or 850 ticks (long). Until it expires, recall codes are dropped.

Top module: `flash_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is released, `line_n` is 1 and `tx_mute`, `dial_mute`, `kbd_inhibit`, `rdptr_clr` and `fwd_vld` are 0. Reset also clears any running spacing window, so a recall code is accepted right after reset.
- R2: A strobe with `code` equal to `RECALL_CODE` (default 16) that arrives outside a spacing window starts a break. `line_n` goes to 0 at the next clock edge.
- R3: With `dur_long` at 0 when the break starts, `line_n` returns to 1 at the clock edge that samples the `BRK_SHORT_MS`-th tick counted after the start cycle.
- R4: With `dur_long` at 1 when the break starts, the break lasts `BRK_LONG_MS` ticks. Changing `dur_long` during a break does not change its length.
- R5: `rdptr_clr` is high for exactly one cycle: the first cycle of each break.
- R6: A code that arrives while `line_n` is 0 is not forwarded.
- R7: Outside a break, a non-recall code appears on `fwd_code` with `fwd_vld` high in the next cycle. A recall code is never forwarded.
- R8: A recall code is discarded with no effect on any output until `LOCK_SHORT_MS` (short) or `LOCK_LONG_MS` (long) ticks have been counted from the start of the previous break.
- R9: `tx_mute`, `dial_mute` and `kbd_inhibit` are 1 exactly in the cycles where `line_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dur_long | input | 1 | Break length select: 1 long, 0 short |
| code_vld | input | 1 | Key code strobe |
| code | input | CODE_W | Key code |
| line_n | output | 1 | Line control, 0 during a break |
| tx_mute | output | 1 | Transmit mute |
| dial_mute | output | 1 | Dialing mute |
| kbd_inhibit | output | 1 | Keyboard entries ignored |
| rdptr_clr | output | 1 | Clear pulse to the redial read pointer |
| fwd_vld | output | 1 | Forwarded code valid |
| fwd_code | output | CODE_W | Forwarded code for the redial store |

## Verification
The bench builds the block with break lengths of 3 and 7 ticks and spacing windows of 10 and 12 ticks. It keeps the default 5-bit code and recall value 16. With these small values, every tick boundary can be reached within a few hundred cycles: the last tick before a break ends, the tick that ends it, and a recall one tick before and exactly at the end of each spacing window. A synchronous reset in the middle of a break is also covered.

// File: rtl/flash_pkg.sv
package flash_pkg;

   typedef enum logic {
      DUR_SHORT = 1'b0,
      DUR_LONG  = 1'b1
   } dur_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/flash_tmr.sv
module flash_tmr #(
   parameter int W        = 10,
   parameter int TOP_SHORT = 100,
   parameter int TOP_LONG  = 600
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic load,
   input  flash_pkg::dur_e sel,
   output logic active
);
   localparam logic [W-1:0] LD_S = W'(TOP_SHORT);
   localparam logic [W-1:0] LD_L = W'(TOP_LONG);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (sel == flash_pkg::DUR_LONG) ? LD_L : LD_S;
      end else if (tick && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign active = (cnt != '0);

   assert_load_arms_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> active);

   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
   parameter int               CODE_W      = 5,
   parameter logic [CODE_W-1:0] RECALL_CODE = 5'd16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              code_vld,
   input  logic [CODE_W-1:0] code,
   input  logic              brk_act,
   input  logic              lock_act,
   output logic              start,
   output logic              rdptr_clr,
   output logic              fwd_vld,
   output logic [CODE_W-1:0] fwd_code
);
   logic is_recall;

   assign is_recall = (code == RECALL_CODE);
   assign start     = code_vld && is_recall && !lock_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         rdptr_clr <= 1'b0;
         fwd_vld   <= 1'b0;
         fwd_code  <= '0;
      end else begin
         rdptr_clr <= start;
         fwd_vld   <= code_vld && !is_recall && !brk_act;
         if (code_vld && !is_recall && !brk_act) begin
            fwd_code <= code;
         end
      end
   end

   assert_clr_single_R5: assert property (@(posedge clk) disable iff (rst)
      rdptr_clr |=> !rdptr_clr);

   assert_recall_kept_R7: assert property (@(posedge clk) disable iff (rst)
      fwd_vld |-> fwd_code != RECALL_CODE);

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
   parameter int               CODE_W        = 5,
   parameter logic [CODE_W-1:0] RECALL_CODE   = 5'd16,
   parameter int               BRK_SHORT_MS  = 100,
   parameter int               BRK_LONG_MS   = 600,
   parameter int               LOCK_SHORT_MS = 810,
   parameter int               LOCK_LONG_MS  = 850
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ms_tick,
   input  logic              dur_long,
   input  logic              code_vld,
   input  logic [CODE_W-1:0] code,
   output logic              line_n,
   output logic              tx_mute,
   output logic              dial_mute,
   output logic              kbd_inhibit,
   output logic              rdptr_clr,
   output logic              fwd_vld,
   output logic [CODE_W-1:0] fwd_code
);
   import flash_pkg::*;

   localparam int CNT_W = $clog2(max2(max2(LOCK_SHORT_MS, LOCK_LONG_MS),
                                      max2(BRK_SHORT_MS, BRK_LONG_MS)) + 1);
   localparam int T_SHORT [2] = '{BRK_SHORT_MS, LOCK_SHORT_MS};
   localparam int T_LONG  [2] = '{BRK_LONG_MS,  LOCK_LONG_MS};

   if (BRK_SHORT_MS < 1 || BRK_LONG_MS < 1) begin : g_bad_brk
      $error("flash_ctrl: break lengths must be at least one tick");
   end
   if (LOCK_SHORT_MS <= BRK_SHORT_MS || LOCK_LONG_MS <= BRK_LONG_MS) begin : g_bad_lock
      $error("flash_ctrl: spacing window must outlast its break");
   end
   if (CODE_W < 1) begin : g_bad_w
      $error("flash_ctrl: code width must be positive");
   end

   logic [1:0] act;
   logic       start;
   dur_e       sel;

   assign sel = dur_long ? DUR_LONG : DUR_SHORT;

   for (genvar i = 0; i < 2; i++) begin : g_tmr
      flash_tmr #(
         .W        (CNT_W),
         .TOP_SHORT(T_SHORT[i]),
         .TOP_LONG (T_LONG[i])
      ) u_tmr (
         .clk   (clk),
         .rst   (rst),
         .tick  (ms_tick),
         .load  (start),
         .sel   (sel),
         .active(act[i])
      );
   end

   flash_seq #(
      .CODE_W     (CODE_W),
      .RECALL_CODE(RECALL_CODE)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .code_vld (code_vld),
      .code     (code),
      .brk_act  (act[0]),
      .lock_act (act[1]),
      .start    (start),
      .rdptr_clr(rdptr_clr),
      .fwd_vld  (fwd_vld),
      .fwd_code (fwd_code)
   );

   assign line_n      = !act[0];
   assign tx_mute     = act[0];
   assign dial_mute   = act[0];
   assign kbd_inhibit = act[0];

   assert_clr_in_break_R5: assert property (@(posedge clk) disable iff (rst)
      rdptr_clr |-> !line_n);

   assert_break_in_lock_R8: assert property (@(posedge clk) disable iff (rst)
      act[0] |-> act[1]);

   assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (rst)
      act[1] |=> !rdptr_clr);

   assert_quiet_in_break_R6: assert property (@(posedge clk) disable iff (rst)
      (!line_n && $past(!line_n)) |-> !fwd_vld);

   assert_recall_starts_R2: assert property (@(posedge clk) disable iff (rst)
      (code_vld && code == RECALL_CODE && !act[1]) |=> (!line_n && rdptr_clr));

endmodule

// File: tb/tb_flash_ctrl.sv
module tb_flash_ctrl;
   localparam int CW = 5;
   localparam logic [CW-1:0] RC = 5'd16;
   localparam int BS = 3, BL = 7, LS = 10, LL = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ms_tick = 1'b0, dur_long = 1'b0, code_vld = 1'b0;
   logic [CW-1:0] code = '0;
   logic line_n, tx_mute, dial_mute, kbd_inhibit, rdptr_clr, fwd_vld;
   logic [CW-1:0] fwd_code;

   int n_chk = 0, n_fail = 0;
   logic [CW-1:0] q_fwd[$];
   int q_brk[$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_ctrl #(.CODE_W(CW), .RECALL_CODE(RC), .BRK_SHORT_MS(BS), .BRK_LONG_MS(BL),
                .LOCK_SHORT_MS(LS), .LOCK_LONG_MS(LL)) dut (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .dur_long(dur_long),
      .code_vld(code_vld), .code(code), .line_n(line_n), .tx_mute(tx_mute),
      .dial_mute(dial_mute), .kbd_inhibit(kbd_inhibit), .rdptr_clr(rdptr_clr),
      .fwd_vld(fwd_vld), .fwd_code(fwd_code));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // driver: pushes expected forwards, returns one negedge after the strobe edge
   task automatic send(input logic [CW-1:0] c, input bit expect_fwd);
      if (expect_fwd) q_fwd.push_back(c);
      @(negedge clk) begin code_vld = 1'b1; code = c; end
      @(negedge clk) code_vld = 1'b0;
   endtask

   task automatic chk_idle(input string req);
      chk(line_n == 1'b1, req, line_n, 1);
      chk({tx_mute, dial_mute, kbd_inhibit} == 3'b000, req,
          {tx_mute, dial_mute, kbd_inhibit}, 0);
   endtask

   task automatic chk_break(input string req);
      chk(line_n == 1'b0, req, line_n, 0);
      chk({tx_mute, dial_mute, kbd_inhibit} == 3'b111, req,
          {tx_mute, dial_mute, kbd_inhibit}, 7);
   endtask

   // monitor: forwarded codes and measured break lengths
   int brk_ticks = 0;
   logic prev_line = 1'b1;
   always @(negedge clk) begin
      #1;
      if (!rst && fwd_vld) begin
         if (q_fwd.size() == 0) chk(1'b0, "R6/R7 unexpected forward", fwd_code, -1);
         else begin
            automatic logic [CW-1:0] e = q_fwd.pop_front();
            chk(fwd_code == e, "R7 forwarded code", fwd_code, e);
         end
      end
      if (line_n == 1'b0 && prev_line == 1'b1) brk_ticks = 0;
      if (line_n == 1'b0 && ms_tick) brk_ticks++;
      if (line_n == 1'b1 && prev_line == 1'b0) begin
         if (q_brk.size() == 0) chk(1'b0, "R3/R4 unexpected break", brk_ticks, -1);
         else begin
            automatic int e = q_brk.pop_front();
            chk(brk_ticks == e, "R3/R4 break length", brk_ticks, e);
         end
      end
      prev_line = line_n;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      chk(rdptr_clr == 1'b0 && fwd_vld == 1'b0, "R1 pulses", rdptr_clr, 0);
      rst = 1'b0;
      @(negedge clk);
      chk_idle("R1 after reset");

      send(5'd3, 1'b1);                       // R7 digit forwarded in idle
      send(5'd11, 1'b1);

      // short flash
      dur_long = 1'b0;
      q_brk.push_back(BS);
      send(RC, 1'b0);
      chk_break("R2 short start");
      chk_break("R9 short start");
      chk(rdptr_clr == 1'b1, "R5 clear pulse", rdptr_clr, 1);
      chk(fwd_vld == 1'b0, "R7 recall not forwarded", fwd_vld, 0);
      @(negedge clk);
      chk(rdptr_clr == 1'b0, "R5 clear one cycle", rdptr_clr, 0);
      send(5'd9, 1'b0);                       // R6 ignored in break
      chk(fwd_vld == 1'b0, "R6 no forward in break", fwd_vld, 0);
      dur_long = 1'b1;                        // R4 no effect mid-break
      ticks(BS - 1);
      chk_break("R3 still low before last tick");
      tick();
      chk_idle("R3 short break ended");
      chk_idle("R9 mutes released");

      // lockout after the break
      send(RC, 1'b0);
      chk(line_n == 1'b1 && rdptr_clr == 1'b0, "R8 recall in window", line_n, 1);
      send(5'd7, 1'b1);                       // R7 forwarded after break
      ticks(LS - BS - 1);
      send(RC, 1'b0);
      chk(line_n == 1'b1 && rdptr_clr == 1'b0, "R8 one tick before window end", line_n, 1);
      tick();

      // long flash at window end
      dur_long = 1'b1;
      q_brk.push_back(BL);
      send(RC, 1'b0);
      chk_break("R8 accepted at window end");
      chk(rdptr_clr == 1'b1, "R5 clear pulse long", rdptr_clr, 1);
      dur_long = 1'b0;
      ticks(BL - 1);
      chk_break("R4 still low before last tick");
      tick();
      chk_idle("R4 long break ended");
      ticks(LL - BL - 1);
      send(RC, 1'b0);
      chk(line_n == 1'b1 && rdptr_clr == 1'b0, "R8 long window one tick early", line_n, 1);
      tick();

      // reset in the middle of a break
      q_brk.push_back(1);
      send(RC, 1'b0);
      chk_break("R2 start before reset");
      tick();
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      chk_idle("R1 reset mid-break");
      rst = 1'b0;
      @(negedge clk);
      q_brk.push_back(BS);
      send(RC, 1'b0);
      chk_break("R1 window cleared by reset");
      ticks(BS);
      chk_idle("R3 break after reset");
      repeat (3) @(negedge clk);

      chk(q_fwd.size() == 0, "R7 forwards outstanding", q_fwd.size(), 0);
      chk(q_brk.size() == 0, "R3 breaks outstanding", q_brk.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule